// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block converts the two phase signals of an incremental quadrature encoder into a position count held in a 16-bit register. Both phase inputs are assumed to be clean and already synchronous to the single internal clock. Each clock the block compares them with their values from the previous cycle. A qualifying edge on one phase moves the count up or down by one. Which edges qualify is chosen by a two-bit sensitivity code. The count runs over the closed range from zero to a programmable reload value and wraps at both ends, so it always shows the encoder's position modulo the reload value plus one.

The block also records the current count direction. It raises sticky flags when the direction reverses: one flag for a turn to counting up and one for a turn to counting down. A single-cycle write-one strobe clears each flag. Each flag has its own interrupt enable, and the interrupt output reflects only reversals that happened while that enable was set. All ports are plain control and status signals, because no data stream enters or leaves the block, so there is no valid/ready handshake and no back-pressure.

Top module: `qenc_pos_counter`

## Requirements
- R1: After reset, `position` is 0, `dir_down` is 0 (up), and `flag_up`, `flag_down` and `irq` are 0.
- R2: With `edge_sel` = 2'b00 (rising), a rising edge on `phase_a` counts up when `phase_b` is low and down when it is high. A rising edge on `phase_b` counts up when `phase_a` is high and down when it is low. Falling edges do not count.
- R3: With `edge_sel` = 2'b01 (falling), a falling edge on `phase_a` counts up when `phase_b` is high and down when it is low. A falling edge on `phase_b` counts up when `phase_a` is low and down when it is high. Rising edges do not count.
- R4: With `edge_sel` = 2'b10 (both), every edge on either phase counts, following the R2 and R3 rules. With `edge_sel` = 2'b11, nothing counts.
- R5: If both phases change in the same clock, the count does not move.
- R6: Counting up from a value at or above `reload_val` gives 0. Counting down from 0, or from a value above `reload_val`, gives `reload_val`. After any step, `position` <= `reload_val`.
- R7: While `enable` is low, `position` is held at 0, `dir_down` is held at 0, and edges are ignored.
- R8: A down step while the direction is up sets `flag_down`, and an up step while the direction is down sets `flag_up`. A one-cycle high on `clr_down`/`clr_up` clears the flag. A new setting event in the same cycle wins over the clear. The flags keep their value through disable.
- R9: `irq` is high while an up (down) reversal is pending that occurred with `ie_up` (`ie_down`) high. Setting the enable after its flag is already set does not raise `irq`. The matching clear strobe, or dropping the enable, removes that source.
- R10: A phase level first seen at a clock edge updates `position`, `dir_down` and the flags on that same edge, so they are visible one clock after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Counter enable; low holds count and direction at start state |
| edge_sel | input | 2 | Edge sensitivity: 00 rising, 01 falling, 10 both, 11 off |
| reload_val | input | 16 | Upper bound of the count range |
| phase_a | input | 1 | Encoder phase A |
| phase_b | input | 1 | Encoder phase B |
| clr_up | input | 1 | Write-one clear strobe for `flag_up` |
| clr_down | input | 1 | Write-one clear strobe for `flag_down` |
| ie_up | input | 1 | Interrupt enable for up reversals |
| ie_down | input | 1 | Interrupt enable for down reversals |
| position | output | 16 | Current position count |
| dir_down | output | 1 | Current direction, 1 = down |
| flag_up | output | 1 | Sticky reversal-to-up flag |
| flag_down | output | 1 | Sticky reversal-to-down flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong edge qualification or direction decode shows up on `position` one clock after the offending phase change. A stale previous-sample register makes the count move on a cycle with no input change, and this too is visible on the next clock. A direction register that fails to follow the steps shows up only at the next reversal, as a missing or extra `flag_up`/`flag_down` and, if the enable is set, on `irq`. For that reason the stimulus reverses direction often under each sensitivity code. A wrong wrap bound is visible the moment the count crosses zero or the reload value.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    SENS_RISE = 2'b00,
    SENS_FALL = 2'b01,
    SENS_BOTH = 2'b10,
    SENS_OFF  = 2'b11
  } sens_e;

  localparam int unsigned NUM_PH = 2;  // phase inputs: 0 = A, 1 = B
  localparam int unsigned IDX_UP = 0;  // flag index for reversal to up
  localparam int unsigned IDX_DN = 1;  // flag index for reversal to down

  // Does a transition to new level 'lvl' count under sensitivity 's'?
  function automatic logic edge_counts(sens_e s, logic lvl);
    case (s)
      SENS_RISE: return lvl;
      SENS_FALL: return ~lvl;
      SENS_BOTH: return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/qenc_edge_decode.sv
module qenc_edge_decode
  import qenc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  sens_e sens,
  input  logic  ph_a,
  input  logic  ph_b,
  output logic  step_up,
  output logic  step_down
);
  logic [NUM_PH-1:0] cur, prev_q, chg, qual, fwd;
  logic              primed_q, single, hit, hit_fwd;

  assign cur = {ph_b, ph_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= cur;
      primed_q <= 1'b1;
    end
  end

  assign chg = cur ^ prev_q;

  genvar i;
  generate
    for (i = 0; i < NUM_PH; i++) begin : g_ph
      assign qual[i] = edge_counts(sens, cur[i]);
      // Phase A moves up when A and B differ after its edge; phase B when they match.
      if (i == 0) begin : g_a
        assign fwd[i] = ph_a ^ ph_b;
      end else begin : g_b
        assign fwd[i] = ~(ph_a ^ ph_b);
      end
    end
  endgenerate

  assign single   = $onehot(chg);
  assign hit      = |(chg & qual);
  assign hit_fwd  = |(chg & fwd);
  assign step_up   = primed_q & enable & single & hit & hit_fwd;
  assign step_down = primed_q & enable & single & hit & ~hit_fwd;

  AST_NO_DOUBLE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (chg == '1) |-> !(step_up || step_down)); // R5
  AST_OFF_OR_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sens == SENS_OFF || !enable) |-> !(step_up || step_down)); // R4
  AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sens == SENS_RISE && (step_up || step_down)) |-> |(chg & cur)); // R2
endmodule

// File: rtl/qenc_wrap_counter.sv
module qenc_wrap_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             step_up,
  input  logic             step_down,
  input  logic [CNT_W-1:0] bound,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!enable) begin
      cnt_d = ZERO;
    end else if (step_up) begin
      cnt_d = (cnt_q >= bound) ? ZERO : cnt_q + ONE;
    end else if (step_down) begin
      cnt_d = (cnt_q == ZERO || cnt_q > bound) ? bound : cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= ZERO;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (step_up || step_down)) |=> cnt_q <= $past(bound)); // R6
  AST_DISABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> cnt_q == ZERO); // R7
  AST_UP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && step_up && cnt_q < bound) |=> (cnt_q - $past(cnt_q)) == ONE); // R2
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !step_up && !step_down) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/qenc_dir_flags.sv
module qenc_dir_flags
  import qenc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              step_up,
  input  logic              step_down,
  input  logic [NUM_PH-1:0] clr,
  input  logic [NUM_PH-1:0] ie,
  output logic              dir_down,
  output logic [NUM_PH-1:0] flag,
  output logic              irq
);
  logic              dir_q;
  logic [NUM_PH-1:0] evt, flag_q, pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dir_q <= 1'b0;
    else if (!enable)   dir_q <= 1'b0;
    else if (step_up)   dir_q <= 1'b0;
    else if (step_down) dir_q <= 1'b1;
  end

  assign evt[IDX_UP] = step_up & dir_q;
  assign evt[IDX_DN] = step_down & ~dir_q;

  genvar i;
  generate
    for (i = 0; i < NUM_PH; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flag_q[i] <= 1'b0;
          pend_q[i] <= 1'b0;
        end else begin
          flag_q[i] <= (flag_q[i] & ~clr[i]) | evt[i];
          pend_q[i] <= ie[i] & ((pend_q[i] & ~clr[i]) | evt[i]);
        end
      end

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[i] && !clr[i]) |=> flag_q[i]); // R8
      AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> flag_q[i]); // R8
      AST_PEND_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[i] |-> flag_q[i]); // R9
    end
  endgenerate

  assign dir_down = dir_q;
  assign flag     = flag_q;
  assign irq      = |pend_q;

  AST_IRQ_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(evt & ie))); // R9
endmodule

// File: rtl/qenc_pos_counter.sv
module qenc_pos_counter
  import qenc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       edge_sel,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             clr_up,
  input  logic             clr_down,
  input  logic             ie_up,
  input  logic             ie_down,
  output logic [CNT_W-1:0] position,
  output logic             dir_down,
  output logic             flag_up,
  output logic             flag_down,
  output logic             irq
);
  logic              s_up, s_dn;
  logic [NUM_PH-1:0] flags;
  sens_e             sens;

  assign sens = sens_e'(edge_sel);

  qenc_edge_decode u_dec (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sens(sens),
    .ph_a(phase_a), .ph_b(phase_b), .step_up(s_up), .step_down(s_dn)
  );

  qenc_wrap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .step_up(s_up),
    .step_down(s_dn), .bound(reload_val), .cnt(position)
  );

  qenc_dir_flags u_flg (
    .clk(clk), .rst_n(rst_n), .enable(enable), .step_up(s_up),
    .step_down(s_dn), .clr({clr_down, clr_up}), .ie({ie_down, ie_up}),
    .dir_down(dir_down), .flag(flags), .irq(irq)
  );

  assign flag_up   = flags[IDX_UP];
  assign flag_down = flags[IDX_DN];

  AST_ONE_FLAG_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(flag_up) && $rose(flag_down))); // R8
endmodule

// File: tb/sim_qenc_pos_counter.sv
module sim_qenc_pos_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  edge_sel = 2'b10;
  logic [15:0] reload_val = 16'd5;
  logic        phase_a = 1'b0, phase_b = 1'b0;
  logic        clr_up = 1'b0, clr_down = 1'b0, ie_up = 1'b0, ie_down = 1'b0;
  logic [15:0] position;
  logic        dir_down, flag_up, flag_down, irq;

  int total = 0, bad = 0, cyc = 0, ph = 0;
  bit running = 1'b0;

  // reference model state
  int  m_pos = 0;
  bit  m_dn = 0, m_fu = 0, m_fd = 0, m_pu = 0, m_pd = 0;
  bit  m_pa = 0, m_pb = 0, m_primed = 0;

  always #5 clk = ~clk;

  qenc_pos_counter u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .edge_sel(edge_sel),
    .reload_val(reload_val), .phase_a(phase_a), .phase_b(phase_b),
    .clr_up(clr_up), .clr_down(clr_down), .ie_up(ie_up), .ie_down(ie_down),
    .position(position), .dir_down(dir_down), .flag_up(flag_up),
    .flag_down(flag_down), .irq(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_dn = 0; m_fu = 0; m_fd = 0; m_pu = 0; m_pd = 0;
      m_pa = 0; m_pb = 0; m_primed = 0;
    end else begin
      bit ca, cb, su, sd, ok, ue, de;
      int arr;
      arr = int'(reload_val);
      ca = (phase_a != m_pa);
      cb = (phase_b != m_pb);
      su = 0; sd = 0;
      if (m_primed && enable && (ca ^ cb)) begin
        if (ca) begin
          ok = (edge_sel == 2'b10) || (edge_sel == 2'b00 && phase_a) || (edge_sel == 2'b01 && !phase_a);
          if (ok) begin if (phase_a != phase_b) su = 1; else sd = 1; end
        end else begin
          ok = (edge_sel == 2'b10) || (edge_sel == 2'b00 && phase_b) || (edge_sel == 2'b01 && !phase_b);
          if (ok) begin if (phase_a == phase_b) su = 1; else sd = 1; end
        end
      end
      m_pa = phase_a; m_pb = phase_b; m_primed = 1;
      ue = su && m_dn;
      de = sd && !m_dn;
      if (!enable) begin
        m_pos = 0; m_dn = 0;
      end else if (su) begin
        m_pos = (m_pos >= arr) ? 0 : m_pos + 1; m_dn = 0;
      end else if (sd) begin
        m_pos = (m_pos == 0 || m_pos > arr) ? arr : m_pos - 1; m_dn = 1;
      end
      m_pu = ie_up && ((m_pu && !clr_up) || ue);
      m_pd = ie_down && ((m_pd && !clr_down) || de);
      m_fu = (m_fu && !clr_up) || ue;
      m_fd = (m_fd && !clr_down) || de;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (running && rst_n) begin
      chk("R6 position vs model", int'(position), m_pos);
      chk("R10 dir_down vs model", int'(dir_down), int'(m_dn));
      chk("R8 flag_up vs model", int'(flag_up), int'(m_fu));
      chk("R8 flag_down vs model", int'(flag_down), int'(m_fd));
      chk("R9 irq vs model", int'(irq), int'(m_pu | m_pd));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_ph(input int p);
    ph = p;
    case (p)
      0: begin phase_a = 0; phase_b = 0; end
      1: begin phase_a = 1; phase_b = 0; end
      2: begin phase_a = 1; phase_b = 1; end
      default: begin phase_a = 0; phase_b = 1; end
    endcase
  endtask

  task automatic fwd(input int n);
    for (int k = 0; k < n; k++) begin set_ph((ph + 1) % 4); tick(2); end
  endtask

  task automatic rev(input int n);
    for (int k = 0; k < n; k++) begin set_ph((ph + 3) % 4); tick(2); end
  endtask

  task automatic pulse_clr(input bit u, input bit d);
    clr_up = u; clr_down = d; tick(1); clr_up = 0; clr_down = 0; tick(1);
  endtask

  initial begin
    logic [15:0] lf;
    tick(3);
    rst_n = 1'b1;
    running = 1'b1;
    tick(1);
    chk("R1 reset position", int'(position), 0);
    chk("R1 reset dir", int'(dir_down), 0);
    chk("R1 reset flags", int'({flag_up, flag_down}), 0);
    chk("R1 reset irq", int'(irq), 0);

    enable = 1; edge_sel = 2'b10; reload_val = 16'd5; ie_down = 1;
    tick(2);
    fwd(7);
    chk("R4 both-edge count with wrap", int'(position), 1);
    rev(3);
    chk("R6 down wrap through zero", int'(position), 4);
    chk("R8 flag_down after reversal", int'(flag_down), 1);
    chk("R9 irq on enabled reversal", int'(irq), 1);
    pulse_clr(0, 1);
    chk("R8 flag_down cleared", int'(flag_down), 0);
    chk("R9 irq dropped by clear", int'(irq), 0);
    fwd(1);
    chk("R8 flag_up after reversal", int'(flag_up), 1);
    ie_up = 1; tick(2);
    chk("R9 late enable keeps irq low", int'(irq), 0);
    pulse_clr(1, 0);

    edge_sel = 2'b00; tick(1);
    fwd(8);
    chk("R2 rising-only count", int'(position), 3);
    edge_sel = 2'b01; tick(1);
    rev(4);
    chk("R3 falling-only count", int'(position), 1);
    edge_sel = 2'b11; tick(1);
    fwd(4);
    chk("R4 code 11 holds count", int'(position), 1);

    edge_sel = 2'b10; tick(1);
    set_ph(3); tick(2);   // A and B both change in one cycle
    chk("R5 simultaneous change ignored", int'(position), 1);
    set_ph(0); #1;
    chk("R10 no update before clock", int'(position), 1);
    tick(1);
    chk("R10 update one clock later", int'(position), 2);

    enable = 0; tick(2);
    fwd(2);
    chk("R7 disabled position zero", int'(position), 0);
    chk("R7 disabled direction up", int'(dir_down), 0);
    enable = 1; tick(2);

    lf = 16'hACE1;
    for (int it = 0; it < 600; it++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[2]) fwd(1); else rev(1);
      if (lf[7:4] == 4'd3) begin edge_sel = lf[9:8]; tick(1); end
      if (lf[7:4] == 4'd5) begin reload_val = 16'(lf[11:10] + 2); tick(1); end
      if (lf[7:4] == 4'd9) pulse_clr(lf[12], lf[13]);
      if (lf[7:4] == 4'd11) begin ie_up = lf[14]; ie_down = lf[15]; tick(1); end
    end
    reload_val = 16'hFFFF; edge_sel = 2'b10; tick(1);
    rev(1);
    chk("R6 wrap to full-range bound", int'(position) <= 16'hFFFF ? 1 : 0, 1);
    tick(4);
    running = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule